// File: doc/BRIEF.md
# PTP Receive Timestamp Inserter

This block sits in the receive byte stream of an Ethernet port. It finds layer-2 PTP event messages and writes a compact ingress timestamp straight into the frame. The timestamp goes into the four-byte reserved field of the PTP header. Software later reads the field back and rebuilds the full time from its own view of the clock. Every frame leaves the block one clock cycle after it enters, whether it was modified or not. Only the content of the reserved field can change.

The block takes the time of the local clock as a seconds count, nanoseconds and a 16-bit fraction of a nanosecond. It captures that time on the first byte of each frame, then subtracts a programmable receive pipeline delay. The delay also has a nanosecond part and a fractional part. A per-type event filter, a bypass control and a mode selector decide whether insertion takes place. All three are expected to stay stable while a frame is passing.

Top module: `ptp_rx_stamper`

## Requirements
- R1: `out_valid`, `out_sof` and `out_eof` repeat `in_valid`, `in_sof` and `in_eof` exactly one clock cycle later, for every beat, including when there are idle cycles inside a frame.
- R2: A frame whose bytes 12 and 13 (counted from 0 at the start-of-frame beat) are not 0x88 followed by 0xF7 leaves the block unchanged.
- R3: When insertion applies, frame bytes 30, 31, 32 and 33 are replaced by the 32-bit word {seconds[1:0], nanoseconds[29:0]}. The word is written most significant byte first, at byte 30.
- R4: The message type is the low nibble of frame byte 14, and the upper nibble is ignored. Insertion applies only for types 0 to 3, and only when bit [type] of `evt_filter` is 1. A filter of 0xF therefore enables all four event types, and 0x0 enables none.
- R5: While `bypass` is 1, every frame leaves the block unchanged.
- R6: Insertion takes place only when `ins_mode` equals 2. Modes 0, 1 and 3 leave frames unchanged.
- R7: The time stamped into a frame is the clock time present on its start-of-frame beat. Changes to the time inputs later in the frame have no effect. The stamped value is that time minus the delay {`rx_dly_ns`, `rx_dly_subns`}, computed with 16 fractional bits. The nanoseconds part is truncated toward zero.
- R8: When the delay is larger than the nanosecond-and-fraction part of the captured time, the result wraps by 1,000,000,000 ns and the seconds value drops by one. For example, seconds bits 0 become 3.
- R9: Bytes outside positions 30 to 33 are never changed. Byte positions count only beats with `in_valid` high.
- R10: After reset, `out_valid` is 0 until the first input beat arrives.
- R11: A frame that ends before byte 30 passes through unchanged. A frame that ends inside the field gets only those field bytes that it contains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| cur_sec | input | SEC_W (32) | Current clock seconds |
| cur_ns | input | 30 | Current clock nanoseconds |
| cur_subns | input | SUB_W (16) | Current clock fraction of a nanosecond |
| rx_dly_ns | input | DLY_W (16) | Receive pipeline delay, whole nanoseconds |
| rx_dly_subns | input | SUB_W (16) | Receive pipeline delay, fraction of a nanosecond |
| evt_filter | input | 4 | One enable bit per event message type 0..3 |
| bypass | input | 1 | Pass all frames unchanged |
| ins_mode | input | 2 | Insertion mode; 2 selects reserved-field insertion |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame at the output |
| out_eof | output | 1 | Last byte of a frame at the output |

## Verification
Every result of this block falls due exactly one cycle after the beat that causes it. The bench records each beat's expected byte and frame markers in a queue as it drives the beat. At the falling edge after the next rising edge, it compares the head of the queue with the outputs, and it also compares `out_valid` with the valid flag held since the previous edge. The expected timestamp comes from the time the bench drove on the start-of-frame beat, reduced by the delay in 64-bit integer arithmetic with a wrap at one second. The bench changes the time inputs on the second beat of every frame, so a design that latches the time late produces a mismatch at bytes 30 to 33 of that same frame.

// File: rtl/ptp_rx_stamper_pkg.sv
// Shared constants and types for the PTP receive timestamp inserter.
// Assumes untagged Ethernet frames with the PTP header right after the EtherType.
package ptp_rx_stamper_pkg;
    localparam logic [15:0] PTP_ETYPE   = 16'h88F7;
    localparam int          ETYPE_POS   = 12;   // first EtherType byte
    localparam int          MTYPE_POS   = 14;   // first PTP header byte
    localparam int          STAMP_POS   = 30;   // PTP header byte 16
    localparam int          STAMP_BYTES = 4;
    localparam int          EVT_TYPES   = 4;
    localparam longint      NS_PER_SEC  = 64'd1000000000;

    typedef enum logic [1:0] {
        INS_OFF0     = 2'd0,
        INS_OFF1     = 2'd1,
        INS_RESERVED = 2'd2,
        INS_OFF3     = 2'd3
    } ins_mode_e;

    typedef logic [31:0] stamp_word_t;
endpackage

// File: rtl/ptp_rx_time_comp.sv
// Subtracts the receive pipeline delay from the captured clock time and packs
// the result into {sec[1:0], ns[29:0]}. Purely combinational.
// Assumes ns_i < 1e9 and a delay below one second.
module ptp_rx_time_comp
    import ptp_rx_stamper_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 16,
    parameter int DLY_W = 16
) (
    input  logic [SEC_W-1:0] sec_i,
    input  logic [29:0]      ns_i,
    input  logic [SUB_W-1:0] subns_i,
    input  logic [DLY_W-1:0] dly_ns_i,
    input  logic [SUB_W-1:0] dly_subns_i,
    output stamp_word_t      stamp_o
);
    localparam int FX_W = 31 + SUB_W;
    localparam logic [FX_W-1:0] SEC_FX = FX_W'(NS_PER_SEC) << SUB_W;

    logic [FX_W-1:0] now_fx, dly_fx, diff_fx;
    logic            borrow;
    logic [1:0]      sec_lo;

    // fixed-point subtraction with wrap at one second
    always_comb begin
        now_fx  = {1'b0, ns_i, subns_i};
        dly_fx  = {{(31-DLY_W){1'b0}}, dly_ns_i, dly_subns_i};
        borrow  = now_fx < dly_fx;
        diff_fx = borrow ? (now_fx + SEC_FX - dly_fx) : (now_fx - dly_fx);
        sec_lo  = sec_i[1:0] - {1'b0, borrow};
        stamp_o = {sec_lo, diff_fx[SUB_W +: 30]};
    end
endmodule

// File: rtl/ptp_rx_frame_track.sv
// Counts valid beats within a frame, recognises the PTP EtherType, evaluates the
// message type against the event filter and flags the beats that fall in the
// reserved field. Assumes every frame starts with a beat that carries sof.
module ptp_rx_frame_track
    import ptp_rx_stamper_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat_valid,
    input  logic                 beat_sof,
    input  logic [7:0]           beat_data,
    input  logic [EVT_TYPES-1:0] evt_filter,
    output logic                 field_hit,
    output logic [1:0]           field_sel
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] ET_HI   = IDX_W'(ETYPE_POS);
    localparam logic [IDX_W-1:0] ET_LO   = IDX_W'(ETYPE_POS + 1);
    localparam logic [IDX_W-1:0] MT_IDX  = IDX_W'(MTYPE_POS);
    localparam logic [IDX_W-1:0] FLD_LO  = IDX_W'(STAMP_POS);
    localparam logic [IDX_W-1:0] FLD_HI  = IDX_W'(STAMP_POS + STAMP_BYTES - 1);

    logic [IDX_W-1:0] idx_q, cur_idx;
    logic             et_hi_q, is_ptp_q, eligible_q;
    logic             type_ok;

    // position of the current beat and filter decision for the type nibble
    always_comb begin
        cur_idx = beat_sof ? '0 : idx_q;
        type_ok = (beat_data[3:0] < 4'(EVT_TYPES)) && evt_filter[beat_data[1:0]];
    end

    // beat counter and per-frame classification state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            et_hi_q    <= 1'b0;
            is_ptp_q   <= 1'b0;
            eligible_q <= 1'b0;
        end else if (beat_valid) begin
            idx_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
            if (beat_sof) begin
                et_hi_q    <= 1'b0;
                is_ptp_q   <= 1'b0;
                eligible_q <= 1'b0;
            end else begin
                if (cur_idx == ET_HI)  et_hi_q    <= (beat_data == PTP_ETYPE[15:8]);
                if (cur_idx == ET_LO)  is_ptp_q   <= et_hi_q && (beat_data == PTP_ETYPE[7:0]);
                if (cur_idx == MT_IDX) eligible_q <= is_ptp_q && type_ok;
            end
        end
    end

    // flag beats inside the reserved field of an eligible frame
    always_comb begin
        field_hit = beat_valid && eligible_q && (cur_idx >= FLD_LO) && (cur_idx <= FLD_HI);
        field_sel = 2'(cur_idx - FLD_LO);
    end
endmodule

// File: rtl/ptp_rx_stamper.sv
// PTP receive timestamp inserter: a one-cycle pipeline stage that overwrites the
// reserved field of layer-2 PTP event messages with a compensated ingress time.
// Assumes filter, bypass, mode and delay stay stable while a frame passes.
module ptp_rx_stamper
    import ptp_rx_stamper_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 16,
    parameter int DLY_W = 16,
    parameter int IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [SEC_W-1:0]     cur_sec,
    input  logic [29:0]          cur_ns,
    input  logic [SUB_W-1:0]     cur_subns,
    input  logic [DLY_W-1:0]     rx_dly_ns,
    input  logic [SUB_W-1:0]     rx_dly_subns,
    input  logic [3:0]           evt_filter,
    input  logic                 bypass,
    input  logic [1:0]           ins_mode,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic                 out_sof,
    output logic                 out_eof
);
    stamp_word_t comp_stamp, stamp_q;
    logic        field_hit;
    logic [1:0]  field_sel;
    logic [7:0]  stamp_byte [STAMP_BYTES];
    logic        do_insert;

    ptp_rx_time_comp #(.SEC_W(SEC_W), .SUB_W(SUB_W), .DLY_W(DLY_W)) u_comp (
        .sec_i       (cur_sec),
        .ns_i        (cur_ns),
        .subns_i     (cur_subns),
        .dly_ns_i    (rx_dly_ns),
        .dly_subns_i (rx_dly_subns),
        .stamp_o     (comp_stamp)
    );

    ptp_rx_frame_track #(.IDX_W(IDX_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (in_valid),
        .beat_sof   (in_sof),
        .beat_data  (in_data),
        .evt_filter (evt_filter),
        .field_hit  (field_hit),
        .field_sel  (field_sel)
    );

    // split the stored word into bytes, most significant first
    for (genvar k = 0; k < STAMP_BYTES; k++) begin : g_bytes
        assign stamp_byte[k] = stamp_q[31 - 8*k -: 8];
    end

    // insertion gate from bypass and mode
    always_comb begin
        do_insert = field_hit && !bypass && (ins_mode_e'(ins_mode) == INS_RESERVED);
    end

    // capture the compensated time on the first beat of each frame
    always_ff @(posedge clk) begin
        if (!rst_n)                 stamp_q <= '0;
        else if (in_valid && in_sof) stamp_q <= comp_stamp;
    end

    // one-cycle output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_valid && in_sof;
            out_eof   <= in_valid && in_eof;
            out_data  <= do_insert ? stamp_byte[field_sel] : in_data;
        end
    end
endmodule

// File: rtl/ptp_rx_stamper_chk.sv
// Checker for ptp_rx_stamper: timing of the output stage and pass-through rules.
module ptp_rx_stamper_chk
    import ptp_rx_stamper_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_sof,
    input logic       in_eof,
    input logic       bypass,
    input logic [1:0] ins_mode,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_sof,
    input logic       out_eof
);
    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R1
    marker_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |-> (out_sof == $past(in_sof) && out_eof == $past(in_eof)));

    // R5
    bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(bypass)) |-> (out_data == $past(in_data)));

    // R6
    mode_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(ins_mode) != 2'(INS_RESERVED))) |-> (out_data == $past(in_data)));

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);
endmodule

bind ptp_rx_stamper ptp_rx_stamper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .bypass    (bypass),
    .ins_mode  (ins_mode),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
);

// File: tb/ptp_rx_stamper_test.sv
// Self-checking bench: sweeps message type against filter, then bypass, modes,
// foreign EtherTypes, delay wrap and short frames.
module ptp_rx_stamper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic [31:0] cur_sec = '0;
    logic [29:0] cur_ns = '0;
    logic [15:0] cur_subns = '0, rx_dly_ns = '0, rx_dly_subns = '0;
    logic [3:0]  evt_filter = '0;
    logic        bypass = 1'b0;
    logic [1:0]  ins_mode = 2'd2;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;

    int vectors = 0, fails = 0;
    int wr_p = 0, rd_p = 0;
    logic [7:0] exp_d [16384];
    logic       exp_s [16384];
    logic       exp_e [16384];
    string      exp_t [16384];
    logic       prev_v = 1'b0;
    logic       mon_on = 1'b0;

    ptp_rx_stamper uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .cur_sec(cur_sec), .cur_ns(cur_ns),
        .cur_subns(cur_subns), .rx_dly_ns(rx_dly_ns), .rx_dly_subns(rx_dly_subns),
        .evt_filter(evt_filter), .bypass(bypass), .ins_mode(ins_mode),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
    );

    always #5 clk = ~clk;

    always @(posedge clk) prev_v <= in_valid;

    // compare outputs one cycle after each beat, at the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            vectors++;
            if (out_valid !== prev_v) begin
                fails++;
                $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, prev_v);
            end
            if (out_valid) begin
                vectors++;
                if (out_data !== exp_d[rd_p]) begin
                    fails++;
                    $display("FAIL %s byte %0d data actual %02h expected %02h",
                             exp_t[rd_p], rd_p, out_data, exp_d[rd_p]);
                end
                if (out_sof !== exp_s[rd_p] || out_eof !== exp_e[rd_p]) begin
                    fails++;
                    $display("FAIL R1 markers actual %0b%0b expected %0b%0b",
                             out_sof, out_eof, exp_s[rd_p], exp_e[rd_p]);
                end
                rd_p++;
            end
        end
    end

    function automatic logic [31:0] model_stamp(longint sec, longint ns, longint sub,
                                                longint dn, longint ds);
        longint t = ns * 65536 + sub - (dn * 65536 + ds);
        longint s = sec;
        logic [63:0] nsv;
        logic [63:0] sv;
        if (t < 0) begin          // R8 wrap
            t = t + 64'd1000000000 * 65536;
            s = s - 1;
        end
        nsv = 64'(t >>> 16);
        sv  = 64'(s);
        return {sv[1:0], nsv[29:0]};
    endfunction

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send_frame(input int len, input logic [15:0] et, input logic [3:0] mt,
                              input logic [3:0] filt, input logic byp, input logic [1:0] md,
                              input longint sec, input longint ns, input longint sub,
                              input longint dn, input longint ds, input bit gaps,
                              input string tag);
        logic [31:0] st;
        logic        ins;
        logic [7:0]  b;
        evt_filter = filt; bypass = byp; ins_mode = md;
        rx_dly_ns = 16'(dn); rx_dly_subns = 16'(ds);
        st  = model_stamp(sec, ns, sub, dn, ds);
        ins = (et == 16'h88F7) && (mt < 4) && filt[mt[1:0]] && !byp && (md == 2'd2);
        for (int i = 0; i < len; i++) begin
            if (i == 12)      b = et[15:8];
            else if (i == 13) b = et[7:0];
            else if (i == 14) b = {4'h3, mt};               // R4 upper nibble ignored
            else if (i >= 30 && i < 34) b = 8'(8'hE0 + i);
            else              b = 8'(i * 3 + 7);
            exp_d[wr_p] = (ins && i >= 30 && i < 34) ? st[31 - 8*(i-30) -: 8] : b;
            exp_s[wr_p] = (i == 0);
            exp_e[wr_p] = (i == len - 1);
            exp_t[wr_p] = (i >= 30 && i < 34) ? tag : "R9";
            wr_p++;
            if (gaps && (i % 7 == 3)) idle();
            @(posedge clk); #1;
            in_valid = 1'b1; in_data = b;
            in_sof = (i == 0); in_eof = (i == len - 1);
            if (i == 0) begin
                cur_sec = 32'(sec); cur_ns = 30'(ns); cur_subns = 16'(sub);
            end else if (i == 1) begin                     // R7 late change ignored
                cur_sec = cur_sec + 32'd1;
                cur_ns = 30'((ns + 123457) % 64'd1000000000);
                cur_subns = cur_subns ^ 16'h5A5A;
            end
        end
        idle(); idle();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin                      // R10
            fails++;
            $display("FAIL R10 out_valid in reset actual %0b expected 0", out_valid);
        end
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin                      // R10
            fails++;
            $display("FAIL R10 out_valid after reset actual %0b expected 0", out_valid);
        end
        mon_on = 1'b1;

        // R3 R4 R7: every type nibble against every filter value
        for (int mt = 0; mt < 16; mt++) begin
            for (int f = 0; f < 16; f++) begin
                longint k = mt * 16 + f;
                send_frame(40, 16'h88F7, 4'(mt), 4'(f), 1'b0, 2'd2,
                           k, (k * 3906251) % 64'd1000000000, (k * 977) % 65536,
                           40 + k % 50, (k * 131) % 65536, bit'(k % 2),
                           (f[mt % 4] && mt < 4) ? "R3" : "R4");
            end
        end
        // R5 bypass
        for (int mt = 0; mt < 4; mt++)
            send_frame(40, 16'h88F7, 4'(mt), 4'hF, 1'b1, 2'd2, 7, 500000, 9, 30, 0, 1'b0, "R5");
        // R6 other modes
        for (int md = 0; md < 4; md++)
            send_frame(40, 16'h88F7, 4'd1, 4'hF, 1'b0, 2'(md), 6, 777777, 3, 20, 0, 1'b1, "R6");
        // R2 foreign EtherTypes
        send_frame(40, 16'h88F6, 4'd0, 4'hF, 1'b0, 2'd2, 1, 1000, 0, 10, 0, 1'b0, "R2");
        send_frame(40, 16'h89F7, 4'd0, 4'hF, 1'b0, 2'd2, 1, 1000, 0, 10, 0, 1'b0, "R2");
        send_frame(40, 16'h0800, 4'd2, 4'hF, 1'b0, 2'd2, 1, 1000, 0, 10, 0, 1'b1, "R2");
        // R8 wrap cases, including seconds bits 0 -> 3 and fraction-only borrow
        send_frame(40, 16'h88F7, 4'd0, 4'hF, 1'b0, 2'd2, 0, 5, 100, 200, 0, 1'b0, "R8");
        send_frame(40, 16'h88F7, 4'd1, 4'hF, 1'b0, 2'd2, 5, 10, 5, 10, 6, 1'b1, "R8");
        send_frame(40, 16'h88F7, 4'd2, 4'hF, 1'b0, 2'd2, 2, 10, 6, 10, 6, 1'b0, "R8");
        send_frame(40, 16'h88F7, 4'd3, 4'hF, 1'b0, 2'd2, 3, 999999999, 65535, 0, 0, 1'b0, "R7");
        // R11 short frames
        send_frame(30, 16'h88F7, 4'd0, 4'hF, 1'b0, 2'd2, 1, 4000, 0, 10, 0, 1'b0, "R11");
        send_frame(32, 16'h88F7, 4'd0, 4'hF, 1'b0, 2'd2, 1, 4000, 0, 10, 0, 1'b1, "R11");
        send_frame(20, 16'h88F7, 4'd1, 4'hF, 1'b0, 2'd2, 1, 4000, 0, 10, 0, 1'b0, "R11");
        send_frame(40, 16'h88F7, 4'd1, 4'hF, 1'b0, 2'd2, 2, 80000, 0, 10, 0, 1'b0, "R11");

        repeat (4) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (rd_p != wr_p) begin                            // R1 every beat emerged
            fails++;
            $display("FAIL R1 bytes out actual %0d expected %0d", rd_p, wr_p);
        end
        finish_run();
    end
endmodule